// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block produces the address bytes that an I2C master puts on the bus at the start of a transfer. A command (read or write) is handed in over a valid/ready pair. When the command is accepted, the block captures the target address and the mode controls: 7-bit or 10-bit addressing, and whether a special command (General Call or START BYTE) is active. It then presents one address byte at a time to the bit-level engine. Each byte carries a flag that says whether a START or repeated START must come before it.

A read requested while General Call is selected is illegal. Such a read is consumed without emitting any byte, and it raises a sticky abort flag that stays set until the abort-clear input is pulsed. General Call stays in force for every command for as long as the special-command control holds that selection. Bit-level timing, acknowledge handling and data bytes belong to the engine downstream.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset `abortFlag` is 0, `byteValid` is 0 and `cmdReady` is 1.
- R2: In 7-bit mode with `specialEn`=0, an accepted command yields one byte `{tarAddr[6:0], rw}` with `byteStart`=1. In that byte, bit 0 is 1 for a read and 0 for a write.
- R3: In 10-bit mode with `specialEn`=0, a write yields two bytes. The first is `{5'b11110, tarAddr[9:8], 1'b0}` with `byteStart`=1. The second is `tarAddr[7:0]` with `byteStart`=0.
- R4: A 10-bit read yields the two bytes of R3, then `{5'b11110, tarAddr[9:8], 1'b1}` with `byteStart`=1, which marks a repeated START.
- R5: While `specialEn`=0, the value of `gcOrStart` has no effect on the bytes produced.
- R6: With `specialEn`=1 and `gcOrStart`=0, a write yields the single byte 0x00 with `byteStart`=1, whatever `tarAddr` and `tenBitSel` hold.
- R7: With `specialEn`=1 and `gcOrStart`=0, a read sets `abortFlag` in the cycle after acceptance. It emits no byte, and `cmdReady` stays 1. This applies to every such command while the selection is held.
- R8: With `specialEn`=1 and `gcOrStart`=1, a command first yields 0x01 with `byteStart`=1. It then yields the normal 7-bit or 10-bit sequence of R2 to R4, and the first byte of that sequence has `byteStart`=1.
- R9: `abortFlag` stays set until `abortClr` is pulsed. If a new abort and `abortClr` fall in the same cycle, the flag stays set.
- R10: While `byteValid`=1 and `byteReady`=0, `byteData` and `byteStart` hold their values and `cmdReady` is 0. A byte is consumed on a clock edge where both `byteValid` and `byteReady` are 1.
- R11: `tarAddr`, `tenBitSel` and the read/write choice are captured when the command is accepted. Changing `tarAddr` later does not alter the bytes of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tarAddr | input | 10 | Target address |
| tenBitSel | input | 1 | 1 selects 10-bit addressing |
| specialEn | input | 1 | 1 enables a special command |
| gcOrStart | input | 1 | Special command kind: 0 General Call, 1 START BYTE |
| cmdValid | input | 1 | Command request |
| cmdRead | input | 1 | 1 for read, 0 for write |
| cmdReady | output | 1 | Block can accept a command |
| byteValid | output | 1 | An address byte is presented |
| byteData | output | 8 | Address byte |
| byteStart | output | 1 | START or repeated START must come before this byte |
| byteReady | input | 1 | Downstream engine takes the byte |
| abortFlag | output | 1 | Sticky transmit abort |
| abortClr | input | 1 | Clears the abort flag |

## Verification
The abort-setting path and the abort-clearing input can act in the same cycle. This happens when a General Call read is accepted on the very edge where `abortClr` is pulsed. The bench provokes this from a cleared flag by driving `cmdValid`, `cmdRead` and `abortClr` together. It expects `abortFlag` to be 1 afterwards and clears it with a separate, lone pulse. The bench also checks that a clear pulse does not disturb a flag that is set again by a later illegal read.

// File: rtl/i2c_addr_seq_pkg.sv
package i2c_addr_seq_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int PFX_W  = 5;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam logic [PFX_W-1:0]  TEN_PREFIX = 5'b11110;
  localparam logic [BYTE_W-1:0] GC_CODE    = 8'h00;
  localparam logic [BYTE_W-1:0] SB_CODE    = 8'h01;

  typedef enum logic [2:0] {
    STEP_IDLE, STEP_GC, STEP_SB, STEP_FIRST, STEP_SECOND, STEP_REREAD
  } seqStepE;

  typedef struct packed {
    logic    load;
    logic    setAbort;
    seqStepE step;
  } ctlStrobeT;
endpackage

// File: rtl/i2c_addr_seq_ctrl.sv
module i2c_addr_seq_ctrl
  import i2c_addr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdRead,
  input  logic      specialEn,
  input  logic      gcOrStart,
  input  logic      byteReady,
  input  logic      latTen,
  input  logic      latRead,
  output logic      cmdReady,
  output logic      byteValid,
  output ctlStrobeT stb
);
  seqStepE step, stepNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= STEP_IDLE;
    else       step <= stepNxt;
  end

  always_comb begin
    stepNxt      = step;
    stb.load     = 1'b0;
    stb.setAbort = 1'b0;
    stb.step     = step;
    cmdReady     = (step == STEP_IDLE);
    byteValid    = (step != STEP_IDLE);
    case (step)
      STEP_IDLE: if (cmdValid) begin
        stb.load = 1'b1;
        if (specialEn && !gcOrStart) begin
          if (cmdRead) stb.setAbort = 1'b1;
          else         stepNxt = STEP_GC;
        end else if (specialEn) begin
          stepNxt = STEP_SB;
        end else begin
          stepNxt = STEP_FIRST;
        end
      end
      STEP_GC:     if (byteReady) stepNxt = STEP_IDLE;
      STEP_SB:     if (byteReady) stepNxt = STEP_FIRST;
      STEP_FIRST:  if (byteReady) stepNxt = latTen ? STEP_SECOND : STEP_IDLE;
      STEP_SECOND: if (byteReady) stepNxt = latRead ? STEP_REREAD : STEP_IDLE;
      STEP_REREAD: if (byteReady) stepNxt = STEP_IDLE;
      default:     stepNxt = STEP_IDLE;
    endcase
  end
endmodule

// File: rtl/i2c_addr_seq_dp.sv
module i2c_addr_seq_dp
  import i2c_addr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         stb,
  input  logic [ADDR_W-1:0] tarAddr,
  input  logic              tenBitSel,
  input  logic              cmdRead,
  input  logic              abortClr,
  output logic              latTen,
  output logic              latRead,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteStart,
  output logic              abortFlag
);
  logic [ADDR_W-1:0] latAddr;
  logic [BYTE_W-1:0] tenHead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latTen  <= 1'b0;
      latRead <= 1'b0;
    end else if (stb.load) begin
      latAddr <= tarAddr;
      latTen  <= tenBitSel;
      latRead <= cmdRead;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             abortFlag <= 1'b0;
    else if (stb.setAbort) abortFlag <= 1'b1;
    else if (abortClr)     abortFlag <= 1'b0;
  end

  assign tenHead = {TEN_PREFIX, latAddr[ADDR_W-1 -: HI_W], 1'b0};

  always_comb begin
    byteData  = '0;
    byteStart = 1'b1;
    case (stb.step)
      STEP_GC:     byteData = GC_CODE;
      STEP_SB:     byteData = SB_CODE;
      STEP_FIRST:  byteData = latTen ? tenHead : {latAddr[BYTE_W-2:0], latRead};
      STEP_SECOND: begin
        byteData  = latAddr[BYTE_W-1:0];
        byteStart = 1'b0;
      end
      STEP_REREAD: byteData = tenHead | BYTE_W'(1);
      default: begin
        byteData  = '0;
        byteStart = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] tarAddr,
  input  logic              tenBitSel,
  input  logic              specialEn,
  input  logic              gcOrStart,
  input  logic              cmdValid,
  input  logic              cmdRead,
  output logic              cmdReady,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteStart,
  input  logic              byteReady,
  output logic              abortFlag,
  input  logic              abortClr
);
  ctlStrobeT stb;
  logic      latTen, latRead;

  i2c_addr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .specialEn(specialEn), .gcOrStart(gcOrStart), .byteReady(byteReady),
    .latTen(latTen), .latRead(latRead), .cmdReady(cmdReady),
    .byteValid(byteValid), .stb(stb)
  );

  i2c_addr_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tarAddr(tarAddr),
    .tenBitSel(tenBitSel), .cmdRead(cmdRead), .abortClr(abortClr),
    .latTen(latTen), .latRead(latRead), .byteData(byteData),
    .byteStart(byteStart), .abortFlag(abortFlag)
  );
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [6:0] tarLow,
  input logic       tenBitSel,
  input logic       specialEn,
  input logic       gcOrStart,
  input logic       cmdValid,
  input logic       cmdRead,
  input logic       cmdReady,
  input logic       byteValid,
  input logic [7:0] byteData,
  input logic       byteStart,
  input logic       byteReady,
  input logic       abortFlag,
  input logic       abortClr
);
  logic accepted;
  assign accepted = cmdValid && cmdReady;

  // R7
  gc_read_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && specialEn && !gcOrStart && cmdRead |=> abortFlag && !byteValid && cmdReady);

  // R9
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortFlag && !abortClr |=> abortFlag);

  // R6
  gc_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && specialEn && !gcOrStart && !cmdRead |=> byteValid && byteData == 8'h00 && byteStart);

  // R8
  start_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && specialEn && gcOrStart |=> byteValid && byteData == 8'h01 && byteStart);

  // R2
  seven_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !specialEn && !tenBitSel |=>
      byteData == {$past(tarLow), $past(cmdRead)} && byteStart);

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteData) && $stable(byteStart) && !cmdReady);
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .tarLow(tarAddr[6:0]), .tenBitSel(tenBitSel),
  .specialEn(specialEn), .gcOrStart(gcOrStart), .cmdValid(cmdValid),
  .cmdRead(cmdRead), .cmdReady(cmdReady), .byteValid(byteValid),
  .byteData(byteData), .byteStart(byteStart), .byteReady(byteReady),
  .abortFlag(abortFlag), .abortClr(abortClr)
);

// File: tb/i2c_addr_seq_tb.sv
module i2c_addr_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] tarAddr = '0;
  logic       tenBitSel = 1'b0, specialEn = 1'b0, gcOrStart = 1'b0;
  logic       cmdValid = 1'b0, cmdRead = 1'b0, byteReady = 1'b0, abortClr = 1'b0;
  logic       cmdReady, byteValid, byteStart, abortFlag;
  logic [7:0] byteData;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .tarAddr(tarAddr), .tenBitSel(tenBitSel),
    .specialEn(specialEn), .gcOrStart(gcOrStart), .cmdValid(cmdValid),
    .cmdRead(cmdRead), .cmdReady(cmdReady), .byteValid(byteValid),
    .byteData(byteData), .byteStart(byteStart), .byteReady(byteReady),
    .abortFlag(abortFlag), .abortClr(abortClr)
  );

  task automatic checkVal(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(bit rd, bit clr);
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = rd; abortClr = clr;
    @(posedge clk); #1;
    cmdValid = 1'b0; abortClr = 1'b0;
  endtask

  task automatic takeByte(string req, logic [7:0] expData, bit expStart);
    @(negedge clk);
    checkVal(req, "byteValid", byteValid, 1);
    checkVal(req, "byteData", byteData, expData);
    checkVal(req, "byteStart", byteStart, expStart);
    byteReady = 1'b1;
    @(posedge clk); #1;
    byteReady = 1'b0;
  endtask

  task automatic expectIdle(string req);
    @(negedge clk);
    checkVal(req, "idle byteValid", byteValid, 0);
    checkVal(req, "idle cmdReady", cmdReady, 1);
  endtask

  task automatic pulseClr();
    @(negedge clk); abortClr = 1'b1;
    @(posedge clk); #1; abortClr = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    checkVal("R1", "abortFlag", abortFlag, 0);
    checkVal("R1", "byteValid", byteValid, 0);
    checkVal("R1", "cmdReady", cmdReady, 1);
  endtask

  task automatic tSevenBit();
    tarAddr = 10'h3A5; tenBitSel = 0; specialEn = 0; gcOrStart = 1; // R5: gcOrStart ignored
    sendCmd(0, 0); takeByte("R2 R5", 8'h4A, 1); expectIdle("R2");
    sendCmd(1, 0); takeByte("R2 R5", 8'h4B, 1); expectIdle("R2");
  endtask

  task automatic tTenBit();
    tarAddr = 10'h2B7; tenBitSel = 1; specialEn = 0; gcOrStart = 0;
    sendCmd(0, 0); takeByte("R3", 8'hF4, 1); takeByte("R3", 8'hB7, 0); expectIdle("R3");
    sendCmd(1, 0); takeByte("R4", 8'hF4, 1); takeByte("R4", 8'hB7, 0);
    takeByte("R4", 8'hF5, 1); expectIdle("R4");
  endtask

  task automatic tStall();
    tarAddr = 10'h011; tenBitSel = 0; specialEn = 0;
    sendCmd(0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkVal("R10", "held data", byteData, 8'h22);
      checkVal("R10", "held cmdReady", cmdReady, 0);
      if (i == 1) tarAddr = 10'h07F; // R11: late change
    end
    takeByte("R11", 8'h22, 1); expectIdle("R10");
  endtask

  task automatic tGeneralCall();
    tarAddr = 10'h155; tenBitSel = 1; specialEn = 1; gcOrStart = 0;
    sendCmd(0, 0); takeByte("R6", 8'h00, 1); expectIdle("R6");
    sendCmd(1, 0);
    @(negedge clk);
    checkVal("R7", "abortFlag", abortFlag, 1);
    checkVal("R7", "no byte", byteValid, 0);
    checkVal("R7", "cmdReady", cmdReady, 1);
    sendCmd(0, 0); takeByte("R6", 8'h00, 1);
    @(negedge clk); checkVal("R9", "sticky", abortFlag, 1);
    pulseClr();
    @(negedge clk); checkVal("R9", "cleared", abortFlag, 0);
    sendCmd(1, 0); // persists: second read also aborts
    @(negedge clk);
    checkVal("R7", "abort again", abortFlag, 1);
    checkVal("R7", "no byte again", byteValid, 0);
    pulseClr();
  endtask

  task automatic tSetWins();
    specialEn = 1; gcOrStart = 0;
    @(negedge clk); checkVal("R9", "pre clear", abortFlag, 0);
    sendCmd(1, 1);
    @(negedge clk); checkVal("R9", "set beats clear", abortFlag, 1);
    pulseClr();
    @(negedge clk); checkVal("R9", "lone clear", abortFlag, 0);
  endtask

  task automatic tStartByte();
    specialEn = 1; gcOrStart = 1; tenBitSel = 0; tarAddr = 10'h033;
    sendCmd(1, 0); takeByte("R8", 8'h01, 1); takeByte("R8", 8'h67, 1); expectIdle("R8");
    tenBitSel = 1; tarAddr = 10'h1C4;
    sendCmd(0, 0); takeByte("R8", 8'h01, 1); takeByte("R8", 8'hF2, 1);
    takeByte("R8", 8'hC4, 0); expectIdle("R8");
    @(negedge clk); checkVal("R8", "no abort", abortFlag, 0);
  endtask

  task automatic tGcLeft();
    specialEn = 0; gcOrStart = 0; tenBitSel = 0; tarAddr = 10'h05A;
    sendCmd(1, 0); takeByte("R5", 8'hB5, 1); expectIdle("R5");
    @(negedge clk); checkVal("R7", "read allowed after leaving", abortFlag, 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tSevenBit();
    tTenBit();
    tStall();
    tGeneralCall();
    tSetWins();
    tStartByte();
    tGcLeft();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule